// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block classifies every memory access that the processor or an external bus master issues. It first applies an optional A20 wrap to the address. Accesses made in system management mode skip this wrap. It then decides where the resulting address lies: in one of three fixed graphics windows, in one of sixteen 16 KB segments that cover C0000h–FFFFFh, below a programmable top-of-memory boundary, or above it.

For each access, one cycle later, the block reports the effective address and four permission flags: read, write, cacheable and bus-master. It also reports whether the access was blocked, whether it fell outside system memory, and whether it should be steered to the graphics pipeline.

Software programs the decoder through a small synchronous write port of 32-bit registers. The lookup itself is purely combinational from the wrapped address, and its result is registered once at the output.

Top module: `legacy_region_decoder`

## Requirements
- R1: After reset, every region attribute bit, every steering bit, the A20 wrap bit and the top-of-memory value are zero. All result outputs are low until the first access is reported.
- R2: When bit 21 of control register 0 is set, a non-SMM access has address bit 20 cleared. The cleared address is both reported and used for classification.
- R3: An access flagged as SMM is never wrapped. Its reported address equals the requested address.
- R4: An address outside A0000h–FFFFFh and below top of memory (register 1) gets read, write and bus-master permission. It is cacheable exactly when the access requests caching.
- R5: An address outside A0000h–FFFFFh and at or above top of memory is flagged above-top. It has no permissions and is blocked.
- R6: The windows A0000h–AFFFFh, B0000h–B7FFFh and B8000h–BFFFFh take their attributes from register 2, with window k in bits [4k+3:4k]. Within each nibble, bit 0 is read, bit 1 is write, bit 2 is cache and bit 3 is bus-master.
- R7: Segment n covers C0000h + n·4000h up to the next segment. Segments 0–7 take their nibble from register 3 and segments 8–15 from register 4, each at bits [4m+3:4m] with m = n mod 8, using the same bit order as R6.
- R8: The cacheable output is high only when the region's cache bit is set and the access requests caching.
- R9: An access is blocked when its direction bit (write for writes, read for reads) is clear, or when it comes from a bus master and the master bit is clear.
- R10: Bits [2:0] of register 0 enable steering for windows 0–2. The route-to-graphics output is high only for an access inside a window whose steering bit is set.
- R11: The results of an access appear on the cycle after it is presented, together with res_valid. In cycles without an access, every result output is zero.
- R12: Configuration writes to register indices 5–7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_cache_req | input | 1 | Access requests cacheable handling |
| acc_master | input | 1 | Access originates from an external bus master |
| acc_smm | input | 1 | Access made in system management mode |
| res_valid | output | 1 | Result valid |
| res_addr | output | 32 | Address after A20 wrap |
| res_read_ok | output | 1 | Read permitted |
| res_write_ok | output | 1 | Write permitted |
| res_cacheable | output | 1 | Access may be cached |
| res_master_ok | output | 1 | Bus-master access permitted |
| res_to_gfx | output | 1 | Steer access to graphics pipeline |
| res_blocked | output | 1 | Access refused by attributes |
| res_above_top | output | 1 | Address outside system memory |

## Verification
The bench probes the first and last byte of every window and segment. A decoder with an off-by-one bound would therefore hand a neighbour's attributes to these addresses. It sets distinct nibbles per region, so a swapped lane or word index shows up as wrong permissions.

A20 tests cover addresses that, once wrapped, fall into a graphics window. They also repeat these addresses under SMM, which catches a wrap that ignores SMM or a classifier that reads the unwrapped address.

Bus-master accesses into regions whose master bit is clear must come out blocked, even when the direction bit is set. Writes to the unused register indices are followed by accesses whose result would change if any state had been disturbed.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

   // Attribute nibble: bit0 read, bit1 write, bit2 cache, bit3 master
   typedef struct packed {
      logic ms;
      logic ca;
      logic wr;
      logic rd;
   } lrd_attr_t;

   localparam int REG_CTRL = 0;
   localparam int REG_TOP  = 1;
   localparam int REG_WIN  = 2;
   localparam int REG_SEG0 = 3;
   localparam int A20_BIT  = 21;
   localparam int LANES_PER_WORD = 8;

   localparam logic [31:0] LEGACY_LO = 32'h000A_0000;
   localparam logic [31:0] LEGACY_HI = 32'h0010_0000;
   localparam logic [31:0] SEG_BASE  = 32'h000C_0000;

   function automatic logic [31:0] win_lo(input int k);
      case (k)
         0:       return 32'h000A_0000;
         1:       return 32'h000B_0000;
         default: return 32'h000B_8000;
      endcase
   endfunction

   function automatic logic [31:0] win_hi(input int k);
      case (k)
         0:       return 32'h000B_0000;
         1:       return 32'h000B_8000;
         default: return 32'h000C_0000;
      endcase
   endfunction

endpackage

// File: rtl/lrd_cfg_regs.sv
module lrd_cfg_regs
   import lrd_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int NUM_WIN = 3,
   parameter int NUM_SEG = 16,
   parameter int CFG_AW  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic              a20_mask,
   output logic [NUM_WIN-1:0] steer,
   output logic [ADDR_W-1:0] top,
   output lrd_attr_t         win_attr [NUM_WIN],
   output lrd_attr_t         seg_attr [NUM_SEG]
);

   logic sel_ctrl, sel_top, sel_win;
   assign sel_ctrl = cfg_we && (cfg_addr == CFG_AW'(REG_CTRL));
   assign sel_top  = cfg_we && (cfg_addr == CFG_AW'(REG_TOP));
   assign sel_win  = cfg_we && (cfg_addr == CFG_AW'(REG_WIN));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a20_mask <= 1'b0;
         steer    <= '0;
      end else if (sel_ctrl) begin
         a20_mask <= cfg_wdata[A20_BIT];
         steer    <= cfg_wdata[NUM_WIN-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         top <= '0;
      else if (sel_top)
         top <= cfg_wdata[ADDR_W-1:0];
   end

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
      always_ff @(posedge clk) begin
         if (!rst_n)
            win_attr[k] <= '0;
         else if (sel_win)
            win_attr[k] <= lrd_attr_t'(cfg_wdata[4*k +: 4]);
      end
   end

   for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
      localparam int WORD = REG_SEG0 + i / LANES_PER_WORD;
      localparam int LANE = i % LANES_PER_WORD;
      always_ff @(posedge clk) begin
         if (!rst_n)
            seg_attr[i] <= '0;
         else if (cfg_we && (cfg_addr == CFG_AW'(WORD)))
            seg_attr[i] <= lrd_attr_t'(cfg_wdata[4*LANE +: 4]);
      end
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (!a20_mask && steer == '0 && top == '0)); // R1

endmodule

// File: rtl/lrd_a20_gate.sv
module lrd_a20_gate
   import lrd_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              mask_en,
   input  logic              smm,
   output logic [ADDR_W-1:0] addr_out
);

   always_comb begin
      addr_out = addr_in;
      if (mask_en && !smm)
         addr_out[A20_BIT-1] = 1'b0;
   end

endmodule

// File: rtl/lrd_region_lookup.sv
module lrd_region_lookup
   import lrd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int NUM_WIN   = 3,
   parameter int NUM_SEG   = 16,
   parameter int SEG_SHIFT = 14
) (
   input  logic [ADDR_W-1:0]  maddr,
   input  logic [ADDR_W-1:0]  top,
   input  logic [NUM_WIN-1:0] steer,
   input  lrd_attr_t          win_attr [NUM_WIN],
   input  lrd_attr_t          seg_attr [NUM_SEG],
   output lrd_attr_t          attr,
   output logic               to_gfx,
   output logic               above_top
);

   logic [31:0] m32, t32;
   assign m32 = 32'(maddr);
   assign t32 = 32'(top);

   logic [NUM_WIN-1:0] win_hit;
   logic [NUM_SEG-1:0] seg_hit;
   logic               in_legacy;

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_win_hit
      assign win_hit[k] = (m32 >= win_lo(k)) && (m32 < win_hi(k));
   end

   for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg_hit
      localparam logic [31:0] LO = SEG_BASE + (32'(i) << SEG_SHIFT);
      localparam logic [31:0] HI = LO + (32'd1 << SEG_SHIFT);
      assign seg_hit[i] = (m32 >= LO) && (m32 < HI);
   end

   assign in_legacy = (m32 >= LEGACY_LO) && (m32 < LEGACY_HI);

   always_comb begin
      logic [3:0] bits;
      logic       gfx;
      bits = '0;
      gfx  = 1'b0;
      for (int k = 0; k < NUM_WIN; k++) begin
         if (win_hit[k]) begin
            bits = bits | win_attr[k];
            gfx  = gfx | steer[k];
         end
      end
      for (int i = 0; i < NUM_SEG; i++) begin
         if (seg_hit[i])
            bits = bits | seg_attr[i];
      end
      above_top = !in_legacy && (m32 >= t32);
      if (!in_legacy)
         bits = above_top ? 4'h0 : 4'hF;
      attr   = lrd_attr_t'(bits);
      to_gfx = gfx;
   end

endmodule

// File: rtl/legacy_region_decoder.sv
module legacy_region_decoder
   import lrd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int NUM_WIN   = 3,
   parameter int NUM_SEG   = 16,
   parameter int SEG_SHIFT = 14,
   parameter int CFG_AW    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              acc_cache_req,
   input  logic              acc_master,
   input  logic              acc_smm,
   output logic              res_valid,
   output logic [ADDR_W-1:0] res_addr,
   output logic              res_read_ok,
   output logic              res_write_ok,
   output logic              res_cacheable,
   output logic              res_master_ok,
   output logic              res_to_gfx,
   output logic              res_blocked,
   output logic              res_above_top
);

   localparam int NUM_REGS = REG_SEG0 + (NUM_SEG + LANES_PER_WORD - 1) / LANES_PER_WORD;

   if (ADDR_W < 21 || ADDR_W > 32) begin : g_bad_addr_w
      $error("ADDR_W must lie in 21..32");
   end
   if (NUM_WIN != 3) begin : g_bad_num_win
      $error("NUM_WIN must be 3");
   end
   if ((NUM_SEG << SEG_SHIFT) != 32'h0004_0000) begin : g_bad_seg
      $error("segments must tile C0000h-FFFFFh exactly");
   end
   if ((1 << CFG_AW) < NUM_REGS) begin : g_bad_cfg_aw
      $error("CFG_AW too small for register count");
   end

   logic              a20_mask;
   logic [NUM_WIN-1:0] steer;
   logic [ADDR_W-1:0] top;
   lrd_attr_t         win_attr [NUM_WIN];
   lrd_attr_t         seg_attr [NUM_SEG];
   logic [ADDR_W-1:0] maddr;
   lrd_attr_t         attr;
   logic              to_gfx, above_top;

   lrd_cfg_regs #(
      .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .NUM_SEG(NUM_SEG), .CFG_AW(CFG_AW)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .a20_mask(a20_mask), .steer(steer), .top(top),
      .win_attr(win_attr), .seg_attr(seg_attr)
   );

   lrd_a20_gate #(.ADDR_W(ADDR_W)) u_a20 (
      .addr_in(acc_addr), .mask_en(a20_mask), .smm(acc_smm), .addr_out(maddr)
   );

   lrd_region_lookup #(
      .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .NUM_SEG(NUM_SEG), .SEG_SHIFT(SEG_SHIFT)
   ) u_lookup (
      .maddr(maddr), .top(top), .steer(steer), .win_attr(win_attr),
      .seg_attr(seg_attr), .attr(attr), .to_gfx(to_gfx), .above_top(above_top)
   );

   logic dir_ok, blocked;
   assign dir_ok  = acc_write ? attr.wr : attr.rd;
   assign blocked = !dir_ok || (acc_master && !attr.ms);

   always_ff @(posedge clk) begin
      if (!rst_n || !acc_valid) begin
         res_valid     <= 1'b0;
         res_addr      <= '0;
         res_read_ok   <= 1'b0;
         res_write_ok  <= 1'b0;
         res_cacheable <= 1'b0;
         res_master_ok <= 1'b0;
         res_to_gfx    <= 1'b0;
         res_blocked   <= 1'b0;
         res_above_top <= 1'b0;
      end else begin
         res_valid     <= 1'b1;
         res_addr      <= maddr;
         res_read_ok   <= attr.rd;
         res_write_ok  <= attr.wr;
         res_cacheable <= attr.ca && acc_cache_req;
         res_master_ok <= attr.ms;
         res_to_gfx    <= to_gfx;
         res_blocked   <= blocked;
         res_above_top <= above_top;
      end
   end

   AST_A20_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !acc_smm && a20_mask |=> !res_addr[A20_BIT-1]); // R2
   AST_SMM_EXEMPT: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_smm |=> res_addr == $past(acc_addr)); // R3
   AST_LOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_above_top && 32'(res_addr) < LEGACY_LO
      |-> res_read_ok && res_write_ok && res_master_ok && !res_blocked); // R4
   AST_ABOVE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      res_above_top |-> !res_read_ok && !res_write_ok && !res_cacheable
                        && !res_master_ok && res_blocked); // R5
   AST_CACHE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      res_cacheable |-> $past(acc_cache_req)); // R8
   AST_GFX_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      res_to_gfx |-> 32'(res_addr) >= LEGACY_LO && 32'(res_addr) < SEG_BASE); // R10
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> res_valid); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> res_addr == '0 && !res_read_ok && !res_write_ok && !res_cacheable
                     && !res_master_ok && !res_to_gfx && !res_blocked && !res_above_top); // R11

endmodule

// File: tb/sim_legacy_region_decoder.sv
`timescale 1ns/1ps
module sim_legacy_region_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_write = 1'b0, acc_cache_req = 1'b0, acc_master = 1'b0, acc_smm = 1'b0;
   logic        res_valid, res_read_ok, res_write_ok, res_cacheable, res_master_ok;
   logic        res_to_gfx, res_blocked, res_above_top;
   logic [31:0] res_addr;

   int checks = 0;
   int errors = 0;

   // bench-side configuration image
   bit          m_a20 = 0;
   bit [2:0]    m_steer = 0;
   bit [31:0]   m_top = 0;
   bit [11:0]   m_win = 0;
   bit [31:0]   m_seg [2] = '{0, 0};

   always #4 clk = ~clk;   // 125 MHz

   legacy_region_decoder u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
      .acc_cache_req(acc_cache_req), .acc_master(acc_master), .acc_smm(acc_smm),
      .res_valid(res_valid), .res_addr(res_addr), .res_read_ok(res_read_ok),
      .res_write_ok(res_write_ok), .res_cacheable(res_cacheable), .res_master_ok(res_master_ok),
      .res_to_gfx(res_to_gfx), .res_blocked(res_blocked), .res_above_top(res_above_top)
   );

   // {valid, addr, rd, wr, ca, ms, gfx, blk, above}
   function automatic logic [39:0] model(bit v, bit [31:0] a, bit w, bit cr, bit ms, bit smm);
      bit [31:0] m;
      bit [3:0]  nib;
      bit        gfx, above, blk;
      int        n;
      if (!v) return '0;
      m = a;
      if (m_a20 && !smm) m[20] = 1'b0;
      gfx = 0; above = 0;
      if (m >= 32'hA0000 && m < 32'h100000) begin
         if (m < 32'hB0000)      begin nib = m_win[3:0];  gfx = m_steer[0]; end
         else if (m < 32'hB8000) begin nib = m_win[7:4];  gfx = m_steer[1]; end
         else if (m < 32'hC0000) begin nib = m_win[11:8]; gfx = m_steer[2]; end
         else begin
            n = int'((m - 32'hC0000) / 32'h4000);
            nib = 4'((m_seg[n / 8] >> (4 * (n % 8))) & 32'hF);
         end
      end else if (m >= m_top) begin
         nib = 4'h0; above = 1;
      end else
         nib = 4'hF;
      blk = (w ? !nib[1] : !nib[0]) || (ms && !nib[3]);
      return {1'b1, m, nib[0], nib[1], nib[2] & cr, nib[3], gfx, blk, above};
   endfunction

   task automatic step(bit v, bit [31:0] a, bit w, bit cr, bit ms, bit smm,
                       bit cw, bit [2:0] ca, bit [31:0] cd, string tag);
      logic [39:0] exp_v, act_v;
      @(negedge clk);
      acc_valid = v; acc_addr = a; acc_write = w; acc_cache_req = cr;
      acc_master = ms; acc_smm = smm;
      cfg_we = cw; cfg_addr = ca; cfg_wdata = cd;
      exp_v = model(v, a, w, cr, ms, smm);
      if (cw) begin
         case (ca)
            3'd0: begin m_a20 = cd[21]; m_steer = cd[2:0]; end
            3'd1: m_top = cd;
            3'd2: m_win = cd[11:0];
            3'd3: m_seg[0] = cd;
            3'd4: m_seg[1] = cd;
            default: ;
         endcase
      end
      @(posedge clk);
      #2;
      act_v = {res_valid, res_addr, res_read_ok, res_write_ok, res_cacheable,
               res_master_ok, res_to_gfx, res_blocked, res_above_top};
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s addr=%h: actual %h expected %h", tag, a, act_v, exp_v);
      end
   endtask

   task automatic acc(bit [31:0] a, bit w, bit cr, bit ms, bit smm, string tag);
      step(1, a, w, cr, ms, smm, 0, 0, 0, tag);
   endtask

   task automatic wcfg(bit [2:0] ca, bit [31:0] cd, string tag);
      step(0, 0, 0, 0, 0, 0, 1, ca, cd, tag);
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1: reset state and default decode
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
      acc(32'h0000_1000, 0, 1, 0, 0, "R1");
      acc(32'h000A_0000, 0, 1, 0, 0, "R1");
      acc(32'h0010_1000, 0, 0, 0, 0, "R1");
      // R4 / R5: top of memory
      wcfg(3'd1, 32'h0100_0000, "R5");
      acc(32'h0000_1000, 0, 1, 0, 0, "R4");
      acc(32'h0009_FFFF, 1, 0, 1, 0, "R4");
      acc(32'h0020_0000, 1, 1, 1, 0, "R8");
      acc(32'h00FF_FFFF, 0, 0, 0, 0, "R4");
      acc(32'h0100_0000, 0, 1, 0, 0, "R5");
      acc(32'h0200_0000, 1, 0, 1, 0, "R5");
      // R6: windows with distinct nibbles
      wcfg(3'd2, 32'h0000_0F31, "R6");
      acc(32'h000A_0000, 1, 0, 0, 0, "R9");
      acc(32'h000A_0000, 0, 1, 0, 0, "R6");
      acc(32'h000A_FFFF, 0, 0, 0, 0, "R6");
      acc(32'h000B_0000, 1, 1, 0, 0, "R6");
      acc(32'h000B_7FFF, 0, 0, 1, 0, "R9");
      acc(32'h000B_8000, 1, 1, 1, 0, "R6");
      acc(32'h000B_FFFF, 0, 1, 0, 0, "R8");
      // R7: segments
      wcfg(3'd3, 32'h7654_3210, "R7");
      wcfg(3'd4, 32'hFEDC_BA98, "R7");
      for (int n = 0; n < 16; n++) begin
         acc(32'hC0000 + 32'(n) * 32'h4000, 0, 1, 0, 0, "R7");
         acc(32'hC0000 + 32'(n) * 32'h4000 + 32'h3FFF, 1, 1, 1, 0, "R7");
      end
      // R10: steering
      wcfg(3'd0, 32'h0000_0005, "R10");
      acc(32'h000A_8000, 0, 0, 0, 0, "R10");
      acc(32'h000B_4000, 0, 0, 0, 0, "R10");
      acc(32'h000B_C000, 1, 0, 0, 0, "R10");
      acc(32'h000C_0000, 0, 0, 0, 0, "R10");
      // R2 / R3: A20 wrap and SMM exemption
      wcfg(3'd0, 32'h0020_0005, "R2");
      acc(32'h0010_1000, 0, 1, 0, 0, "R2");
      acc(32'h001A_0000, 1, 0, 0, 0, "R2");
      acc(32'h001B_8000, 0, 1, 1, 0, "R2");
      acc(32'h001A_0000, 1, 0, 0, 1, "R3");
      acc(32'h0010_1000, 0, 1, 0, 1, "R3");
      // R12: unused register indices
      wcfg(3'd5, 32'hFFFF_FFFF, "R12");
      wcfg(3'd6, 32'h0000_0000, "R12");
      wcfg(3'd7, 32'hFFFF_FFFF, "R12");
      acc(32'h000A_0000, 1, 1, 0, 0, "R12");
      acc(32'h0010_1000, 0, 0, 0, 0, "R12");
      acc(32'h000C_0000, 0, 1, 0, 0, "R12");
      acc(32'h0200_0000, 0, 0, 0, 0, "R12");
      // R11: back-to-back and gaps
      for (int i = 0; i < 8; i++) acc(32'h000B_0000 + 32'(i) * 32'h1000, i[0], 1, i[1], 0, "R11");
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
      // random mix
      for (int i = 0; i < 4000; i++) begin
         int sel;
         bit [31:0] a;
         sel = int'($urandom_range(0, 19));
         if (sel == 0) begin
            int r;
            bit [31:0] tops [4] = '{32'h0, 32'h80000, 32'h0100_0000, 32'hFFFF_FFFF};
            r = int'($urandom_range(0, 4));
            case (r)
               0: wcfg(3'd0, $urandom & 32'h0020_0007, "R2/R10");
               1: wcfg(3'd1, tops[$urandom_range(0, 3)], "R4/R5");
               2: wcfg(3'd2, $urandom, "R6");
               3: wcfg(3'($urandom_range(3, 4)), $urandom, "R7");
               default: wcfg(3'($urandom_range(5, 7)), $urandom, "R12");
            endcase
         end else if (sel == 1) begin
            step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
         end else begin
            case ($urandom_range(0, 3))
               0: a = $urandom_range(0, 32'h9FFFF);
               1: a = 32'hA0000 + $urandom_range(0, 32'h5FFFF);
               2: a = 32'h1A0000 + $urandom_range(0, 32'h5FFFF);
               default: a = $urandom;
            endcase
            acc(a, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R6/R7/R9");
         end
      end
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule